// File: doc/BRIEF.md
# Hierarchically banked dual-port RAM

This block is a two-port synchronous RAM whose storage is split into four quarter-capacity banks. The bank at address zero sits closest to the routing interface and is itself split into four sixteenth-capacity sub-banks. That gives seven physical sub-banks, and each one has its own enable. A static capacity setting tells the block how much of the array the application really uses. In the reduced settings, every access is confined to the nearest quarter or the nearest sixteenth. The other sub-banks then never see an enable, so their bit lines stay quiet.

Each sub-bank has an activity counter that advances on every cycle in which that sub-bank is enabled. A bench or a power study can read these counters to confirm that the gating works.

An access that reaches outside the active capacity is dropped, and it sets a sticky error flag. A capacity setting is taken only on a cycle when both ports are idle.

Top module: `banked_dpram`

## Requirements
- R1: Each port reads or writes on its own in any cycle. Read data appears on the port's rdata one cycle after the read and holds until that port's next accepted read.
- R2: In full mode (capacity 2'b00), address bits [AW-1:AW-2] equal to b>0 enable sub-bank 3+b. When those bits are zero, bits [AW-3:AW-4] pick sub-bank 0..3. Counter i is bank_cnt[i*CNT_W +: CNT_W].
- R3: In quarter mode (capacity 2'b01), only counters 0..3 may change. An access with a nonzero bit in [AW-1:AW-2] raises range_err.
- R4: In sixteenth mode (capacity 2'b10, and 2'b11 treated the same), only counter 0 may change. An access with a nonzero bit in [AW-1:AW-4] raises range_err.
- R5: An out-of-range access writes nothing and leaves that port's rdata unchanged. range_err stays set until reset.
- R6: A sub-bank counter rises by exactly one in each cycle in which at least one port accesses that sub-bank, including when both ports hit it together. Otherwise it holds.
- R7: When both ports write the same address in one cycle, the value from port A is stored.
- R8: When one port writes an address and the other port reads it in the same cycle, the read returns the data from before the write.
- R9: The capacity input is taken only on a cycle with a_en and b_en both low. After reset the mode is full, the counters are zero and range_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cap | input | 2 | Capacity setting: 00 full, 01 quarter, 10/11 sixteenth |
| a_en | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | AW | Port A address |
| a_wdata | input | WIDTH | Port A write data |
| a_rdata | output | WIDTH | Port A read data |
| b_en | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | AW | Port B address |
| b_wdata | input | WIDTH | Port B write data |
| b_rdata | output | WIDTH | Port B read data |
| range_err | output | 1 | Sticky out-of-range access flag |
| bank_cnt | output | 7*CNT_W | Per-sub-bank activity counters, packed |

## Verification
The assertions check several things on every cycle:
- the far quarter banks stay silent in quarter mode, and all sub-banks except sub-bank 0 stay silent in sixteenth mode;
- the mode holds while either port is busy;
- a dropped access always sets the sticky flag;
- each counter holds when its sub-bank is not enabled.

Some behaviour only the bench scenarios can show:
- data correctness across the decode, including port A winning a write collision and old-data return on a read/write clash;
- that an out-of-range write really left memory untouched, which shows up when the address is read back after returning to full mode.

// File: rtl/banked_dpram_pkg.sv
package banked_dpram_pkg;
  // Four quarter banks, the nearest one split into four sixteenths.
  localparam int unsigned N_SIXTEENTH = 4;
  localparam int unsigned N_FAR_QTR   = 3;
  localparam int unsigned NSB         = N_SIXTEENTH + N_FAR_QTR;
  localparam int unsigned SEL_W       = $clog2(NSB);

  typedef enum logic [1:0] {
    CAP_FULL = 2'b00,
    CAP_QTR  = 2'b01,
    CAP_SIX  = 2'b10,
    CAP_SIX2 = 2'b11
  } cap_e;
endpackage

// File: rtl/bank_decode.sv
module bank_decode
  import banked_dpram_pkg::*;
(
  input  logic             en,
  input  logic [3:0]       top4,
  input  cap_e             cap,
  output logic [NSB-1:0]   hit,
  output logic [SEL_W-1:0] idx,
  output logic             ok,
  output logic             bad
);
  logic [1:0] top2;
  logic [1:0] mid2;
  logic       outside;

  always_comb begin
    top2 = top4[3:2];
    mid2 = top4[1:0];
    unique case (cap)
      CAP_FULL: outside = 1'b0;
      CAP_QTR:  outside = (top2 != 2'b00);
      default:  outside = (top4 != 4'b0000);
    endcase
    if (top2 == 2'b00) idx = SEL_W'(mid2);
    else               idx = SEL_W'(top2) + SEL_W'(N_SIXTEENTH - 1);
    ok  = en && !outside;
    bad = en && outside;
    hit = ok ? (NSB'(1) << idx) : '0;
  end
endmodule

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int unsigned LW    = 4,
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             en,
  input  logic             a_act,
  input  logic             a_we,
  input  logic [LW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wd,
  output logic [WIDTH-1:0] a_rd,
  input  logic             b_act,
  input  logic             b_we,
  input  logic [LW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_wd,
  output logic [WIDTH-1:0] b_rd
);
  localparam int unsigned DEPTH = 1 << LW;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] a_rd_q;
  logic [WIDTH-1:0] b_rd_q;

  // Nothing in this sub-bank toggles unless the enable is set.
  // Port A write comes last, so it wins an address collision.
  always_ff @(posedge clk) begin
    if (en) begin
      if (b_act && b_we)  mem[b_addr] <= b_wd;
      if (a_act && a_we)  mem[a_addr] <= a_wd;
      if (a_act && !a_we) a_rd_q <= mem[a_addr];
      if (b_act && !b_we) b_rd_q <= mem[b_addr];
    end
  end

  assign a_rd = a_rd_q;
  assign b_rd = b_rd_q;
endmodule

// File: rtl/act_counter.sv
module act_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = inc ? cnt_q + CNT_W'(1) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_cnt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q));
endmodule

// File: rtl/banked_dpram.sv
module banked_dpram
  import banked_dpram_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_cap,
  input  logic                 a_en,
  input  logic                 a_we,
  input  logic [AW-1:0]        a_addr,
  input  logic [WIDTH-1:0]     a_wdata,
  output logic [WIDTH-1:0]     a_rdata,
  input  logic                 b_en,
  input  logic                 b_we,
  input  logic [AW-1:0]        b_addr,
  input  logic [WIDTH-1:0]     b_wdata,
  output logic [WIDTH-1:0]     b_rdata,
  output logic                 range_err,
  output logic [NSB*CNT_W-1:0] bank_cnt
);
  localparam int unsigned QW = AW - 2;
  localparam int unsigned SW = AW - 4;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_s1, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_n_s <= rst_s1;
    end
  end

  // Capacity mode is taken only on a cycle where both ports are idle.
  cap_e mode_q, mode_d;
  always_comb mode_d = (!a_en && !b_en) ? cap_e'(cfg_cap) : mode_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) mode_q <= CAP_FULL;
    else          mode_q <= mode_d;
  end

  // Per-port decode.
  logic [NSB-1:0]   hit_a, hit_b;
  logic [SEL_W-1:0] idx_a, idx_b;
  logic             ok_a, ok_b, bad_a, bad_b;

  bank_decode u_dec_a (
    .en(a_en), .top4(a_addr[AW-1 -: 4]), .cap(mode_q),
    .hit(hit_a), .idx(idx_a), .ok(ok_a), .bad(bad_a));
  bank_decode u_dec_b (
    .en(b_en), .top4(b_addr[AW-1 -: 4]), .cap(mode_q),
    .hit(hit_b), .idx(idx_b), .ok(ok_b), .bad(bad_b));

  // Sticky error flag.
  logic err_q, err_d;
  always_comb err_d = err_q | bad_a | bad_b;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) err_q <= 1'b0;
    else          err_q <= err_d;
  end
  assign range_err = err_q;

  // Read-steering selects, captured only with an accepted read.
  logic [SEL_W-1:0] sel_a_q, sel_a_d, sel_b_q, sel_b_d;
  always_comb begin
    sel_a_d = (ok_a && !a_we) ? idx_a : sel_a_q;
    sel_b_d = (ok_b && !b_we) ? idx_b : sel_b_q;
  end
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sel_a_q <= '0;
      sel_b_q <= '0;
    end else begin
      sel_a_q <= sel_a_d;
      sel_b_q <= sel_b_d;
    end
  end

  // Sub-banks, enables and activity counters.
  logic [NSB-1:0]   bank_en;
  logic [WIDTH-1:0] rd_a [NSB];
  logic [WIDTH-1:0] rd_b [NSB];
  logic [CNT_W-1:0] cnt  [NSB];

  assign bank_en = hit_a | hit_b;

  for (genvar g = 0; g < NSB; g++) begin : g_bank
    if (g < N_SIXTEENTH) begin : g_six
      bank_ram #(.LW(SW), .WIDTH(WIDTH)) u_ram (
        .clk(clk), .en(bank_en[g]),
        .a_act(hit_a[g]), .a_we(a_we), .a_addr(a_addr[SW-1:0]), .a_wd(a_wdata), .a_rd(rd_a[g]),
        .b_act(hit_b[g]), .b_we(b_we), .b_addr(b_addr[SW-1:0]), .b_wd(b_wdata), .b_rd(rd_b[g]));
    end else begin : g_qtr
      bank_ram #(.LW(QW), .WIDTH(WIDTH)) u_ram (
        .clk(clk), .en(bank_en[g]),
        .a_act(hit_a[g]), .a_we(a_we), .a_addr(a_addr[QW-1:0]), .a_wd(a_wdata), .a_rd(rd_a[g]),
        .b_act(hit_b[g]), .b_we(b_we), .b_addr(b_addr[QW-1:0]), .b_wd(b_wdata), .b_rd(rd_b[g]));
    end
    act_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n_s), .inc(bank_en[g]), .count(cnt[g]));
    assign bank_cnt[g*CNT_W +: CNT_W] = cnt[g];
  end

  // Read-data steering.
  always_comb begin
    a_rdata = '0;
    b_rdata = '0;
    for (int i = 0; i < NSB; i++) begin
      if (sel_a_q == SEL_W'(i)) a_rdata = rd_a[i];
      if (sel_b_q == SEL_W'(i)) b_rdata = rd_b[i];
    end
  end

  // Assertions.
  assert_qtr_gating_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == CAP_QTR) |=> ($stable(cnt[4]) && $stable(cnt[5]) && $stable(cnt[6])));

  assert_six_gating_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    mode_q[1] |=> ($stable(cnt[1]) && $stable(cnt[2]) && $stable(cnt[3]) &&
                   $stable(cnt[4]) && $stable(cnt[5]) && $stable(cnt[6])));

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (a_en || b_en) |=> $stable(mode_q));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    range_err |=> range_err);

  assert_err_raise_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bad_a || bad_b) |=> range_err);
endmodule

// File: tb/banked_dpram_test.sv
module banked_dpram_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 256;
  localparam int WIDTH = 16;
  localparam int CNT_W = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int NB    = 7;
  localparam int QD    = DEPTH / 4;
  localparam int SD    = DEPTH / 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_cap;
  logic a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [WIDTH-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic range_err;
  logic [NB*CNT_W-1:0] bank_cnt;

  always #(CLK_P/2) clk = ~clk;

  banked_dpram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cap(cfg_cap),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .range_err(range_err), .bank_cnt(bank_cnt));

  // Reference model
  int total = 0;
  int bad = 0;
  bit finished = 0;
  string tag = "R9";
  int mode_m = 0;
  bit err_m = 0;
  int cnt_m [NB];
  logic [WIDTH-1:0] mem_m [int];
  logic [WIDTH-1:0] exp_a, exp_b;
  bit known_a = 0, known_b = 0;

  function automatic bit outside(int addr, int mode);
    if (mode == 0) return 0;
    if (mode == 1) return addr >= QD;
    return addr >= SD;
  endfunction

  function automatic int which_bank(int addr);
    if (addr >= QD) return 3 + addr / QD;
    return addr / SD;
  endfunction

  task automatic check(bit cond, string req, longint act, longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit oka, okb;
    int ba, bb;
    oka = a_en && !outside(int'(a_addr), mode_m);
    okb = b_en && !outside(int'(b_addr), mode_m);
    if ((a_en && !oka) || (b_en && !okb)) err_m = 1;
    ba = which_bank(int'(a_addr));
    bb = which_bank(int'(b_addr));
    if (oka && !a_we) begin
      known_a = mem_m.exists(int'(a_addr));
      if (known_a) exp_a = mem_m[int'(a_addr)];
    end
    if (okb && !b_we) begin
      known_b = mem_m.exists(int'(b_addr));
      if (known_b) exp_b = mem_m[int'(b_addr)];
    end
    if (okb && b_we) mem_m[int'(b_addr)] = b_wdata;
    if (oka && a_we) mem_m[int'(a_addr)] = a_wdata;
    for (int i = 0; i < NB; i++)
      if ((oka && ba == i) || (okb && bb == i)) cnt_m[i] = (cnt_m[i] + 1) % (1 << CNT_W);
    if (!a_en && !b_en) mode_m = (cfg_cap == 2'b00) ? 0 : (cfg_cap == 2'b01) ? 1 : 2;
  endtask

  task automatic compare();
    if (known_a) check(a_rdata === exp_a, tag, a_rdata, exp_a);
    if (known_b) check(b_rdata === exp_b, tag, b_rdata, exp_b);
    check(range_err === err_m, tag, range_err, err_m);
    for (int i = 0; i < NB; i++)
      check(bank_cnt[i*CNT_W +: CNT_W] === CNT_W'(cnt_m[i]), tag,
            bank_cnt[i*CNT_W +: CNT_W], cnt_m[i]);
  endtask

  task automatic drive(bit ae, bit aw, int aa, int ad, bit be, bit bw, int bba, int bd);
    a_en = ae; a_we = aw; a_addr = AW'(aa); a_wdata = WIDTH'(ad);
    b_en = be; b_we = bw; b_addr = AW'(bba); b_wdata = WIDTH'(bd);
    @(posedge clk);
    model_step();
    #(CLK_P/4);
    compare();
  endtask

  task automatic idle(); drive(0,0,0,0, 0,0,0,0); endtask

  task automatic set_mode(logic [1:0] m);
    cfg_cap = m;
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) cnt_m[i] = 0;
    rst_n = 1'b0; cfg_cap = 2'b00;
    a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    repeat (3) @(posedge clk);
    #(CLK_P/4) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R9: reset state
    tag = "R9";
    compare();

    // R2 / R1: full-mode decode across every sub-bank, write on A then read on B
    tag = "R2";
    drive(1,1,'h05,'h1111, 0,0,0,0);
    drive(1,1,'h15,'h2222, 1,1,'h25,'h3333);
    drive(1,1,'h35,'h4444, 1,1,'h45,'h5555);
    drive(1,1,'h85,'h6666, 1,1,'hC5,'h7777);
    tag = "R1";
    drive(1,0,'h05,0, 1,0,'h15,0);
    drive(1,0,'h25,0, 1,0,'h35,0);
    drive(1,0,'h45,0, 1,0,'h85,0);
    drive(0,0,0,0, 1,0,'hC5,0);
    idle(); idle();   // R1: rdata holds

    // R7: write collision, port A wins
    tag = "R7";
    drive(1,1,'h20,'hAAAA, 1,1,'h20,'hBBBB);
    drive(1,0,'h20,0, 0,0,0,0);
    // R8: read/write clash returns old data
    tag = "R8";
    drive(1,1,'h21,'h0101, 0,0,0,0);
    drive(1,1,'h21,'h0202, 1,0,'h21,0);
    drive(0,0,0,0, 1,1,'h50,'h0303);
    drive(1,0,'h50,0, 1,1,'h50,'h0404);
    // R6: both ports hit the same sub-bank together -> single step
    tag = "R6";
    drive(1,0,'h45,0, 1,0,'h46,0);
    drive(1,0,'h20,0, 1,0,'h21,0);

    // R1 / R7 / R8: random full-mode traffic
    tag = "R1";
    for (int k = 0; k < 300; k++)
      drive(1'($urandom), 1'($urandom), int'($urandom % DEPTH), int'($urandom % 65536),
            1'($urandom), 1'($urandom), int'($urandom % DEPTH), int'($urandom % 65536));

    // R9: mode change ignored while a port is busy
    tag = "R9";
    cfg_cap = 2'b01;
    drive(1,0,'h45,0, 0,0,0,0);
    cfg_cap = 2'b00;
    drive(1,1,'h46,'hCAFE, 0,0,0,0);   // still full mode: accepted
    drive(1,1,'h47,'hBEEF, 0,0,0,0);

    // R3: quarter mode
    set_mode(2'b01);
    tag = "R3";
    drive(1,1,'h30,'h1234, 1,0,'h05,0);
    drive(1,1,'h47,'hDEAD, 0,0,0,0);    // out of range: suppressed, err set
    tag = "R5";
    drive(1,0,'h30,0, 1,0,'h90,0);     // B read suppressed: rdata holds
    idle();

    // R4: sixteenth mode, both encodings
    set_mode(2'b10);
    tag = "R4";
    drive(1,1,'h0A,'h5A5A, 1,1,'h15,'hFFFF);
    drive(1,0,'h0A,0, 1,0,'h25,0);
    set_mode(2'b11);
    drive(1,0,'h0A,0, 1,1,'h3F,'h9999);
    drive(0,0,0,0, 1,0,'h05,0);

    // R5: back to full, confirm the suppressed writes never landed
    set_mode(2'b00);
    tag = "R5";
    drive(1,0,'h47,0, 1,0,'h15,0);
    drive(1,0,'h3F,0, 0,0,0,0);
    idle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule